// File: doc/BRIEF.md
# MMU Access Check and Fault Logger

This block sits between a translation lookaside buffer and the load/store and fetch pipelines. Each cycle it may accept one translation request: the virtual address, the access size, the write flag, whether the access is an instruction fetch, the address-space attributes of the access (secondary context, no-fault space, the 8-bit space identifier) and the processor state (privilege, address-mask mode, non-zero trap level, hypervisor and reset-error state, real-addressing mode). The request also carries the result of the lookup that the surrounding logic has already performed. The block picks the context the access runs in. It then runs a fixed chain of checks and returns one outcome code and the physical address, one cycle after the request.

When a check fails, the block writes into its own registers. A fault that needs software attention updates a status word, which has a sticky overflow flag. A data-side fault also records the faulting address. A lookup miss records a tag word built from the page-aligned address and the selected context. No register changes on a request that succeeds, on a bypassed request, or on a cycle with no request.

The lookup array and the trap delivery are outside the block. The page size is fixed at 2^PG_BITS bytes.

Top module: `mmu_access_chk`

## Requirements
- R1: Context choice. A non-zero trap level selects context kind nucleus (2), and the context value is 0. Otherwise a data access flagged secondary selects kind secondary (1) with `sec_ctx`. Every other access, including every fetch, selects kind primary (0) with `pri_ctx`. In real-addressing mode the context value is forced to 0 and the kind is kept.
- R2: In hypervisor or reset-error state the checks are skipped. The response is code 0 (no fault) with `rsp_paddr` equal to the low PA_W bits of the virtual address. No register is written.
- R3: The misaligned check (code 1) comes first after the bypass. A fetch fails when any of address bits [2:0] is set. A data access fails when the address ANDed with (2^`req_size_lg` − 1) is non-zero.
- R4: With address-mask mode off, the address is in the hole when bits [VA_W-1:IMPL_W-1] are neither all zero nor all one, and the request gets code 2. With address-mask mode on, there is no hole check, and the effective address keeps only bits [AM_W-1:0].
- R5: A lookup miss gives code 3 in real-addressing mode and code 4 otherwise. It loads `tag_acc` with the effective address with bits [PG_BITS-1:0] cleared, ORed with the context value. It leaves `fsr` and `far` unchanged.
- R6: After a hit the data-side checks run in this order: write to a non-writable page gives code 5; a no-fault page reached without the no-fault space gives code 6; a non-privileged access to a privileged page gives code 7. `rsp_uncache` is set on a data hit to a side-effect page that passes the code 5 and code 6 checks.
- R7: A clean hit returns `rsp_paddr` equal to the frame address with bits [PG_BITS-1:0] cleared, ORed with those bits of the request address. Every faulting response returns address 0.
- R8: Codes 1, 2, 5, 6 and 7 rewrite `fsr`. The fields are:
  - bit 0 = 1;
  - bit 1 = the old bit 0 (sticky overflow);
  - bit 2 = data write;
  - bits [5:4] = context kind;
  - bit 6 = side-effect;
  - bits [9:7] = fault type;
  - bits [16+ASI_W-1:16] = `req_asi`;
  - all other bits 0.

  The side-effect bit is 1 for a data code 2, equals the page's side-effect flag for a data code 5, 6 or 7, and is 0 otherwise. The fault type is 1 (other) for codes 1 and 5, 4 (out of range) for code 2, 5 (no-fault load) for code 6 and 2 (privilege) for code 7. Type 3 (illegal space) is reserved.
- R9: A data request that rewrites `fsr` also loads `far` with its unmasked virtual address. Fetch faults leave `far` unchanged.
- R10: Each accepted request yields exactly one response, with `rsp_valid` high on the following cycle. A cycle without a request yields `rsp_valid` low, code 0, address 0 and `rsp_uncache` low.
- R11: A fetch ignores the write flag and the page's writable, no-fault and side-effect bits. After a hit its only check is the privilege check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_vaddr | input | VA_W | Virtual address |
| req_size_lg | input | 2 | log2 of the data access size in bytes |
| req_write | input | 1 | Data write |
| req_asi | input | ASI_W | Address-space identifier, logged only |
| req_secondary | input | 1 | Data access uses the secondary context |
| req_nofault_as | input | 1 | Access uses a no-fault space |
| st_priv | input | 1 | Privileged mode |
| st_addr_mask | input | 1 | Address-mask mode |
| st_tl_nz | input | 1 | Trap level above zero |
| st_hyper | input | 1 | Hypervisor state |
| st_red | input | 1 | Reset-error state |
| st_real | input | 1 | Real-addressing mode |
| pri_ctx | input | CTX_W | Primary context value |
| sec_ctx | input | CTX_W | Secondary context value |
| tlb_hit | input | 1 | Lookup found a valid entry |
| tlb_pfn | input | PA_W | Frame address of the entry |
| tlb_writable | input | 1 | Entry allows writes |
| tlb_nofault | input | 1 | Entry is a no-fault page |
| tlb_side_eff | input | 1 | Entry has side effects |
| tlb_priv | input | 1 | Entry is privileged |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Outcome code 0..7 |
| rsp_paddr | output | PA_W | Physical address |
| rsp_uncache | output | 1 | Access must be uncacheable |
| fsr | output | 16+ASI_W | Fault status word |
| far | output | VA_W | Data fault address |
| tag_acc | output | VA_W | Miss tag word |

## Verification
The bench builds the block with VA_W=16, IMPL_W=12, AM_W=10, PA_W=14, PG_BITS=6, CTX_W=5 and ASI_W=8. With this configuration the whole 64 Ki address space can be swept in strides. Both hole edges (0x0800 and 0xF7FF) and the masked-mode wrap are hit directly. Every offset and size pairing of the alignment rule is enumerated, and random state mixes push all eight outcome codes, together with back-to-back overflow logging, through a small arithmetic model.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MISALIGN = 3'd1,
    FLT_RANGE    = 3'd2,
    FLT_RMISS    = 3'd3,
    FLT_VMISS    = 3'd4,
    FLT_PROT     = 3'd5,
    FLT_NFO      = 3'd6,
    FLT_PRIV     = 3'd7
  } flt_code_e;

  typedef enum logic [2:0] {
    FT_NONE   = 3'd0,
    FT_OTHER  = 3'd1,
    FT_PRIV   = 3'd2,
    FT_ILL_AS = 3'd3,
    FT_RANGE  = 3'd4,
    FT_NFO    = 3'd5
  } flt_type_e;

  typedef enum logic [1:0] {
    CT_PRIMARY   = 2'd0,
    CT_SECONDARY = 2'd1,
    CT_NUCLEUS   = 2'd2
  } ctx_kind_e;

endpackage

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel
  import mmu_chk_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic             tl_nz,
  input  logic             is_fetch,
  input  logic             use_sec,
  input  logic             real_mode,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output ctx_kind_e        ctx_kind,
  output logic [CTX_W-1:0] ctx_val
);

  always_comb begin
    if (tl_nz)                    ctx_kind = CT_NUCLEUS;
    else if (!is_fetch && use_sec) ctx_kind = CT_SECONDARY;
    else                          ctx_kind = CT_PRIMARY;

    unique case (ctx_kind)
      CT_SECONDARY: ctx_val = sec_ctx;
      CT_PRIMARY:   ctx_val = pri_ctx;
      default:      ctx_val = '0;
    endcase
    if (real_mode) ctx_val = '0;
  end

endmodule

// File: rtl/mmu_fault_prio.sv
module mmu_fault_prio
  import mmu_chk_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int IMPL_W  = 48,
  parameter int AM_W    = 32,
  parameter int PA_W    = 40,
  parameter int PG_BITS = 13
) (
  input  logic            bypass,
  input  logic            is_fetch,
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      size_lg,
  input  logic            is_write,
  input  logic            addr_mask,
  input  logic            nofault_as,
  input  logic            priv,
  input  logic            real_mode,
  input  logic            tlb_hit,
  input  logic [PA_W-1:0] tlb_pfn,
  input  logic            tlb_writable,
  input  logic            tlb_nofault,
  input  logic            tlb_side_eff,
  input  logic            tlb_priv,
  output flt_code_e       flt,
  output logic [VA_W-1:0] eff_va,
  output logic [PA_W-1:0] paddr,
  output logic            uncache,
  output logic            ev_misalign,
  output logic            ev_hole,
  output logic            ev_miss
);

  localparam int HOLE_W = VA_W - IMPL_W + 1;

  function automatic logic [VA_W-1:0] f_low_mask(input int bits);
    logic [VA_W-1:0] m;
    for (int i = 0; i < VA_W; i++) m[i] = (i < bits);
    return m;
  endfunction

  function automatic logic f_misaligned(input logic fetch, input logic [2:0] low,
                                        input logic [1:0] slg);
    logic [3:0] span;
    logic [2:0] m;
    span = 4'd1 << slg;
    m    = 3'(span - 4'd1);
    if (fetch) m = 3'b111;
    return |(low & m);
  endfunction

  function automatic logic f_in_hole(input logic [VA_W-1:0] va);
    logic [HOLE_W-1:0] up;
    up = va[VA_W-1:IMPL_W-1];
    return !((up == '0) || (up == '1));
  endfunction

  function automatic logic [PA_W-1:0] f_join_pa(input logic [PA_W-1:0] pfn,
                                                input logic [VA_W-1:0] va);
    logic [PA_W-1:0] om;
    om = PA_W'(f_low_mask(PG_BITS));
    return (pfn & ~om) | (va[PA_W-1:0] & om);
  endfunction

  logic data_side;
  logic bad_prot, bad_nfo, bad_priv;

  assign ev_misalign = f_misaligned(is_fetch, vaddr[2:0], size_lg);
  assign ev_hole     = !addr_mask && f_in_hole(vaddr);
  assign ev_miss     = !tlb_hit;
  assign eff_va      = addr_mask ? (vaddr & f_low_mask(AM_W)) : vaddr;
  assign data_side   = !is_fetch;
  assign bad_prot    = data_side && is_write && !tlb_writable;
  assign bad_nfo     = data_side && tlb_nofault && !nofault_as;
  assign bad_priv    = !priv && tlb_priv;

  always_comb begin
    paddr   = '0;
    uncache = 1'b0;
    if (bypass) begin
      flt   = FLT_NONE;
      paddr = vaddr[PA_W-1:0];
    end else if (ev_misalign) begin
      flt = FLT_MISALIGN;
    end else if (ev_hole) begin
      flt = FLT_RANGE;
    end else if (ev_miss) begin
      flt = real_mode ? FLT_RMISS : FLT_VMISS;
    end else if (bad_prot) begin
      flt = FLT_PROT;
    end else if (bad_nfo) begin
      flt = FLT_NFO;
    end else begin
      uncache = data_side && tlb_side_eff;
      if (bad_priv) begin
        flt = FLT_PRIV;
      end else begin
        flt   = FLT_NONE;
        paddr = f_join_pa(tlb_pfn, vaddr);
      end
    end
  end

endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_chk_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  parameter int PG_BITS = 13,
  parameter int ASI_W   = 8,
  parameter int SF_W    = 16 + ASI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_we,
  input  logic             addr_we,
  input  logic             tag_we,
  input  logic             wr_bit,
  input  ctx_kind_e        ctx_kind,
  input  logic             se_bit,
  input  flt_type_e        ftype,
  input  logic [ASI_W-1:0] asi,
  input  logic [VA_W-1:0]  eff_va,
  input  logic [VA_W-1:0]  fault_va,
  input  logic [CTX_W-1:0] ctx_val,
  output logic [SF_W-1:0]  fsr,
  output logic [VA_W-1:0]  far,
  output logic [VA_W-1:0]  tag_acc
);

  function automatic logic [SF_W-1:0] f_status(input logic prev_v, input logic wr,
                                               input ctx_kind_e ck, input logic se,
                                               input flt_type_e ft,
                                               input logic [ASI_W-1:0] a);
    logic [SF_W-1:0] w;
    w          = '0;
    w[0]       = 1'b1;
    w[1]       = prev_v;
    w[2]       = wr;
    w[5:4]     = ck;
    w[6]       = se;
    w[9:7]     = ft;
    w[SF_W-1:16] = a;
    return w;
  endfunction

  function automatic logic [VA_W-1:0] f_tag(input logic [VA_W-1:0] va,
                                            input logic [CTX_W-1:0] c);
    return {va[VA_W-1:PG_BITS], {PG_BITS{1'b0}}} | VA_W'(c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr     <= '0;
      far     <= '0;
      tag_acc <= '0;
    end else begin
      if (stat_we) fsr     <= f_status(fsr[0], wr_bit, ctx_kind, se_bit, ftype, asi);
      if (addr_we) far     <= fault_va;
      if (tag_we)  tag_acc <= f_tag(eff_va, ctx_val);
    end
  end

endmodule

// File: rtl/mmu_access_chk.sv
module mmu_access_chk
  import mmu_chk_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int IMPL_W  = 48,
  parameter int AM_W    = 32,
  parameter int PA_W    = 40,
  parameter int PG_BITS = 13,
  parameter int CTX_W   = 13,
  parameter int ASI_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_fetch,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_size_lg,
  input  logic                  req_write,
  input  logic [ASI_W-1:0]      req_asi,
  input  logic                  req_secondary,
  input  logic                  req_nofault_as,
  input  logic                  st_priv,
  input  logic                  st_addr_mask,
  input  logic                  st_tl_nz,
  input  logic                  st_hyper,
  input  logic                  st_red,
  input  logic                  st_real,
  input  logic [CTX_W-1:0]      pri_ctx,
  input  logic [CTX_W-1:0]      sec_ctx,
  input  logic                  tlb_hit,
  input  logic [PA_W-1:0]       tlb_pfn,
  input  logic                  tlb_writable,
  input  logic                  tlb_nofault,
  input  logic                  tlb_side_eff,
  input  logic                  tlb_priv,
  output logic                  rsp_valid,
  output logic [2:0]            rsp_fault,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  rsp_uncache,
  output logic [16+ASI_W-1:0]   fsr,
  output logic [VA_W-1:0]       far,
  output logic [VA_W-1:0]       tag_acc
);

  localparam int SF_W = 16 + ASI_W;

  ctx_kind_e        ctx_kind;
  logic [CTX_W-1:0] ctx_val;
  flt_code_e        flt;
  flt_type_e        ftype;
  logic [VA_W-1:0]  eff_va;
  logic [PA_W-1:0]  paddr_c;
  logic             unc_c, se_bit, logs_status;
  logic             byp_w, ev_misalign, ev_hole, ev_miss;

  assign byp_w = st_hyper || st_red;

  mmu_ctx_sel #(.CTX_W(CTX_W)) ctx_i (
    .tl_nz(st_tl_nz), .is_fetch(req_fetch), .use_sec(req_secondary),
    .real_mode(st_real), .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
    .ctx_kind(ctx_kind), .ctx_val(ctx_val)
  );

  mmu_fault_prio #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .AM_W(AM_W), .PA_W(PA_W), .PG_BITS(PG_BITS)
  ) prio_i (
    .bypass(byp_w), .is_fetch(req_fetch), .vaddr(req_vaddr), .size_lg(req_size_lg),
    .is_write(req_write), .addr_mask(st_addr_mask), .nofault_as(req_nofault_as),
    .priv(st_priv), .real_mode(st_real), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
    .tlb_writable(tlb_writable), .tlb_nofault(tlb_nofault),
    .tlb_side_eff(tlb_side_eff), .tlb_priv(tlb_priv),
    .flt(flt), .eff_va(eff_va), .paddr(paddr_c), .uncache(unc_c),
    .ev_misalign(ev_misalign), .ev_hole(ev_hole), .ev_miss(ev_miss)
  );

  always_comb begin
    logs_status = 1'b1;
    se_bit      = 1'b0;
    unique case (flt)
      FLT_MISALIGN: ftype = FT_OTHER;
      FLT_RANGE: begin
        ftype  = FT_RANGE;
        se_bit = !req_fetch;
      end
      FLT_PROT: begin
        ftype  = FT_OTHER;
        se_bit = !req_fetch && tlb_side_eff;
      end
      FLT_NFO: begin
        ftype  = FT_NFO;
        se_bit = !req_fetch && tlb_side_eff;
      end
      FLT_PRIV: begin
        ftype  = FT_PRIV;
        se_bit = !req_fetch && tlb_side_eff;
      end
      default: begin
        ftype       = FT_NONE;
        logs_status = 1'b0;
      end
    endcase
  end

  mmu_fault_log #(
    .VA_W(VA_W), .CTX_W(CTX_W), .PG_BITS(PG_BITS), .ASI_W(ASI_W), .SF_W(SF_W)
  ) log_i (
    .clk(clk), .rst_n(rst_n),
    .stat_we(req_valid && logs_status),
    .addr_we(req_valid && logs_status && !req_fetch),
    .tag_we(req_valid && (flt == FLT_RMISS || flt == FLT_VMISS)),
    .wr_bit(!req_fetch && req_write), .ctx_kind(ctx_kind), .se_bit(se_bit),
    .ftype(ftype), .asi(req_asi), .eff_va(eff_va), .fault_va(req_vaddr),
    .ctx_val(ctx_val), .fsr(fsr), .far(far), .tag_acc(tag_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 3'd0;
      rsp_paddr   <= '0;
      rsp_uncache <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_fault   <= req_valid ? flt : FLT_NONE;
      rsp_paddr   <= req_valid ? paddr_c : '0;
      rsp_uncache <= req_valid && unc_c;
    end
  end

endmodule

// File: rtl/mmu_access_chk_sva.sv
module mmu_access_chk_sva #(
  parameter int SF_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            byp_w,
  input logic            ev_misalign,
  input logic            rsp_valid,
  input logic [2:0]      rsp_fault,
  input logic            rsp_uncache,
  input logic [SF_W-1:0] fsr
);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && !rsp_uncache));

  // R2
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && byp_w) |=> (rsp_fault == 3'd0 && $stable(fsr)));

  // R3
  misalign_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !byp_w && ev_misalign) |=> rsp_fault == 3'd1);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsr != $past(fsr)) && $past(fsr[0])) |-> fsr[1]);

  // R5
  miss_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault == 3'd3 || rsp_fault == 3'd4)) |-> $stable(fsr));

  // R6
  uncache_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> (rsp_fault == 3'd0 || rsp_fault == 3'd7));

endmodule

bind mmu_access_chk mmu_access_chk_sva #(.SF_W(SF_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .byp_w(byp_w),
  .ev_misalign(ev_misalign), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_uncache(rsp_uncache), .fsr(fsr)
);

// File: tb/mmu_access_chk_tb_top.sv
module mmu_access_chk_tb_top;

  localparam int VA_W = 16, IMPL_W = 12, AM_W = 10, PA_W = 14, PG_BITS = 6;
  localparam int CTX_W = 5, ASI_W = 8, SF_W = 16 + ASI_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid, req_fetch, req_write, req_secondary, req_nofault_as;
  logic [VA_W-1:0] req_vaddr;
  logic [1:0] req_size_lg;
  logic [ASI_W-1:0] req_asi;
  logic st_priv, st_addr_mask, st_tl_nz, st_hyper, st_red, st_real;
  logic [CTX_W-1:0] pri_ctx, sec_ctx;
  logic tlb_hit, tlb_writable, tlb_nofault, tlb_side_eff, tlb_priv;
  logic [PA_W-1:0] tlb_pfn;
  logic rsp_valid, rsp_uncache;
  logic [2:0] rsp_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic [SF_W-1:0] fsr;
  logic [VA_W-1:0] far, tag_acc;

  mmu_access_chk #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .AM_W(AM_W), .PA_W(PA_W), .PG_BITS(PG_BITS),
    .CTX_W(CTX_W), .ASI_W(ASI_W)
  ) dut_i (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  int m_fsr = 0, m_far = 0, m_tag = 0;
  logic [31:0] seed = 32'h1234_5679;

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    s ^= s << 13; s ^= s >> 17; s ^= s << 5;
    return s;
  endfunction

  task automatic defaults();
    req_valid = 1; req_fetch = 0; req_write = 0; req_secondary = 0; req_nofault_as = 0;
    req_vaddr = '0; req_size_lg = 0; req_asi = 8'h80;
    st_priv = 1; st_addr_mask = 0; st_tl_nz = 0; st_hyper = 0; st_red = 0; st_real = 0;
    pri_ctx = 5'd3; sec_ctx = 5'd9;
    tlb_hit = 1; tlb_pfn = 14'h2A40; tlb_writable = 1; tlb_nofault = 0;
    tlb_side_eff = 0; tlb_priv = 0;
  endtask

  // Model the request held on the inputs, advance one cycle, compare.
  task automatic step();
    int va, eff, ct, ctx, f, pa, unc, ft, se, wr, nf, nt, nr;
    bit hole, mis, logs;
    string rq;
    va  = int'(req_vaddr);
    ct  = st_tl_nz ? 2 : ((!req_fetch && req_secondary) ? 1 : 0);
    ctx = (st_tl_nz || st_real) ? 0 : (ct == 1 ? int'(sec_ctx) : int'(pri_ctx));
    eff = st_addr_mask ? va % (1 << AM_W) : va;
    hole = ((va >> (IMPL_W - 1)) != 0) && ((va >> (IMPL_W - 1)) != 31);
    mis = req_fetch ? (va % 8 != 0) : (va % (1 << req_size_lg) != 0);
    pa = 0; unc = 0; ft = 0; se = 0;
    if (st_hyper || st_red) begin f = 0; pa = va % (1 << PA_W); end
    else if (mis) f = 1;
    else if (!st_addr_mask && hole) f = 2;
    else if (!tlb_hit) f = st_real ? 3 : 4;
    else if (!req_fetch && req_write && !tlb_writable) f = 5;
    else if (!req_fetch && tlb_nofault && !req_nofault_as) f = 6;
    else begin
      unc = (!req_fetch && tlb_side_eff) ? 1 : 0;
      if (!st_priv && tlb_priv) f = 7;
      else begin
        f = 0;
        pa = (int'(tlb_pfn) / 64) * 64 + va % 64;
      end
    end
    if (!req_valid) begin f = 0; pa = 0; unc = 0; end
    logs = req_valid && (f == 1 || f == 2 || f == 5 || f == 6 || f == 7);
    case (f)
      1, 5: ft = 1;
      2: ft = 4;
      6: ft = 5;
      7: ft = 2;
      default: ft = 0;
    endcase
    if (!req_fetch && f == 2) se = 1;
    if (!req_fetch && f >= 5) se = tlb_side_eff;
    wr = (!req_fetch && req_write) ? 1 : 0;
    nf = m_fsr; nr = m_far; nt = m_tag;
    if (logs) begin
      nf = ((m_fsr % 2 == 1) ? 3 : 1) + wr * 4 + ct * 16 + se * 64 + ft * 128
           + int'(req_asi) * 65536;
      if (!req_fetch) nr = va;
    end
    if (req_valid && (f == 3 || f == 4)) nt = (eff / 64) * 64 + ctx;
    case (f)
      0: rq = (st_hyper || st_red) ? "R2 bypass" : (req_fetch ? "R11 fetch" : "R7 hit");
      1: rq = "R3 misalign";
      2: rq = "R4 hole";
      3, 4: rq = "R5 miss";
      7: rq = req_fetch ? "R11 fetch priv" : "R6 priv";
      default: rq = "R6 order";
    endcase
    @(posedge clk);
    @(negedge clk);
    check("R10 valid", int'(rsp_valid), int'(req_valid));
    check(rq, int'(rsp_fault), f);
    check((st_hyper || st_red) ? "R2 paddr" : "R7 paddr", int'(rsp_paddr), pa);
    check("R6 uncache", int'(rsp_uncache), unc);
    check("R8 fsr", int'(fsr), nf);
    check("R9 far", int'(far), nr);
    check("R1 R5 tag", int'(tag_acc), nt);
    m_fsr = nf; m_far = nr; m_tag = nt;
  endtask

  initial begin
    defaults();
    req_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset valid", int'(rsp_valid), 0);
    check("R8 reset fsr", int'(fsr), 0);
    check("R9 reset far", int'(far), 0);
    check("R5 reset tag", int'(tag_acc), 0);

    // R8: first logged fault has no overflow, the second sets it
    defaults(); req_vaddr = 16'h0003; req_size_lg = 2; req_write = 1; step();
    check("R8 first no overflow", int'(fsr[1]), 0);
    req_vaddr = 16'h0101; req_fetch = 1; step();
    check("R8 overflow", int'(fsr[1]), 1);

    // R6: ordering among post-hit data checks
    defaults(); req_vaddr = 16'h0040; req_write = 1; tlb_writable = 0;
    tlb_nofault = 1; st_priv = 0; tlb_priv = 1; tlb_side_eff = 1;
    step();
    req_write = 0; step();
    req_nofault_as = 1; step();
    // R11: fetch ignores write and no-fault page bits
    req_fetch = 1; req_write = 1; req_nofault_as = 0; st_priv = 1; step();

    // R1: context kinds via miss tag
    defaults(); tlb_hit = 0; req_vaddr = 16'h07C0;
    step();
    req_secondary = 1; step();
    req_fetch = 1; step();
    req_fetch = 0; st_tl_nz = 1; step();
    st_tl_nz = 0; st_real = 1; step();

    // R2: bypass sweep across address space
    for (int v = 0; v < 65536; v += 37) begin
      defaults(); req_vaddr = 16'(v); st_hyper = (v % 3 != 0); st_red = (v % 3 != 1);
      tlb_hit = v[0]; req_write = v[1]; tlb_writable = 0; st_priv = 0; tlb_priv = 1;
      step();
    end

    // R3: every low offset against every size, both sides
    for (int v = 0; v < 64; v++)
      for (int s = 0; s < 4; s++)
        for (int fe = 0; fe < 2; fe++) begin
          defaults(); req_vaddr = 16'(16'h1F00 + v); req_size_lg = 2'(s);
          req_fetch = fe[0]; step();
        end

    // R4: hole sweep with and without address-mask mode
    for (int v = 0; v < 65536; v += 16)
      for (int am = 0; am < 2; am++) begin
        defaults(); req_vaddr = 16'(v); st_addr_mask = am[0];
        tlb_hit = (v % 64 != 0); step();
      end
    defaults(); req_vaddr = 16'h07F8; step();
    req_vaddr = 16'h0800; step();
    req_vaddr = 16'hF7F8; step();
    req_vaddr = 16'hF800; step();

    // Random mixes of state and lookup results
    for (int n = 0; n < 20000; n++) begin
      logic [31:0] a, b;
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      req_valid = (a[2:0] != 0); req_fetch = a[3]; req_size_lg = a[5:4];
      req_write = a[6]; req_secondary = a[7]; req_nofault_as = a[8];
      st_priv = a[9]; st_addr_mask = a[10]; st_tl_nz = a[11];
      st_hyper = (a[14:12] == 0); st_red = (a[17:15] == 0); st_real = a[18];
      tlb_hit = (a[21:19] != 0); tlb_writable = a[22]; tlb_nofault = a[23];
      tlb_side_eff = a[24]; tlb_priv = a[25];
      req_vaddr = b[15:0];
      if (b[16]) req_vaddr[15:11] = {5{b[17]}};
      if (b[18]) req_vaddr[2:0] = 3'b000;
      tlb_pfn = b[31:18];
      pri_ctx = a[30:26]; sec_ctx = b[23:19]; req_asi = {a[31], b[30:24]};
      step();
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule